// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Slot Buffer

This block receives asynchronous serial frames on a single input line. It samples the line with a sampling strobe that runs at sixteen times the bit rate. From these samples it recovers the start bit, the data bits, an optional ninth bit and the stop bit, and assembles them in a shift register. It leaves the baud-rate divider to the surrounding logic, which supplies the strobe.

Each finished frame is placed in a two-slot buffer. A slot holds the data byte, a framing-error flag and the ninth bit. The oldest slot always drives the head outputs, and a read strobe pops it, which exposes the next slot's data and status. An available flag shows when the buffer holds data, and an interrupt line is that flag gated by an enable input.

When a frame completes while both slots are occupied, the frame is dropped and a sticky overrun flag is raised. While that flag is up, every later frame is also dropped. Driving the receive enable low clears the flag and returns the receiver to idle.

Top module: `uart_rx_fifo2`

## Requirements
- R1: The line passes through a two-flop synchroniser. A falling edge seen on a strobe starts a frame, counted as strobe 0. The start is confirmed only if the majority of the samples at strobes 7, 8 and 9 is low. Otherwise the receiver returns to idle and stores nothing.
- R2: Data bits arrive LSB first, one bit every 16 strobes. Each bit is the majority of its three samples at the bit centre, and the 8 bits appear on `head_data` with bit 0 first on the line.
- R3: When `nine_bit` is high, a ninth bit follows the eighth data bit and is stored as `head_bit9`. When `nine_bit` is low, `head_bit9` is stored as 0.
- R4: A frame whose stop-bit majority is 0 is stored with `head_ferr` = 1. A frame whose stop-bit majority is 1 is stored with `head_ferr` = 0.
- R5: The buffer holds two frames in arrival order. A pop exposes the second frame's data, ferr and bit9 on the head outputs. A pop while the buffer is empty has no effect.
- R6: `data_avail` is high exactly while the buffer holds at least one frame. It rises one clock after a store and falls one clock after the pop that empties the buffer.
- R7: A frame that completes while both slots are occupied sets `overrun` and is discarded. The head frame and the second frame are left unchanged. A pop in the same clock does not free a slot for that frame.
- R8: While `overrun` is high, every completed frame is discarded, even after the buffer has been read empty. `overrun` stays high until `rx_en` goes low.
- R9: While `rx_en` is low, nothing is received, the receiver is held idle and `overrun` is cleared one clock later. The buffered frames are kept.
- R10: `irq` equals `data_avail` AND `int_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling strobe, one clock wide, at 16 times the bit rate |
| rx_en | input | 1 | Receive enable; a low level clears overrun and idles the receiver |
| nine_bit | input | 1 | Selects frames with a ninth data bit |
| rx_in | input | 1 | Serial line, idle high |
| rd_pop | input | 1 | Removes the head frame from the buffer |
| int_en | input | 1 | Interrupt enable |
| head_data | output | DATA_W | Data of the head frame |
| head_ferr | output | 1 | Framing error flag of the head frame |
| head_bit9 | output | 1 | Ninth bit of the head frame |
| overrun | output | 1 | Sticky overrun flag |
| data_avail | output | 1 | Buffer is not empty |
| irq | output | 1 | data_avail gated by int_en |

## Verification
A wrong strobe count or a wrong bit index shows at the ports as a shifted or scrambled `head_data` on the very next frame, so the bench sweeps every byte value. A wrong buffer count shows either as `data_avail` still high after the last pop or as a third frame that is stored instead of raising `overrun`. Both are visible one clock after the pop or the stop-bit decision. A flag that is not sticky shows as a frame that appears after the buffer has been read while `overrun` is still high.

// File: rtl/uart_rx_fifo2.sv
module uart_rx_fifo2 #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              rx_in,
  input  logic              rd_pop,
  input  logic              int_en,
  output logic [DATA_W-1:0] head_data,
  output logic              head_ferr,
  output logic              head_bit9,
  output logic              overrun,
  output logic              data_avail,
  output logic              irq
);

  localparam int CW  = $clog2(OSR);
  localparam int SHW = DATA_W + 1;
  localparam int BW  = $clog2(SHW + 1);
  localparam int EW  = DATA_W + 2;
  localparam logic [CW-1:0] S_A = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] S_B = CW'(OSR/2);
  localparam logic [CW-1:0] S_C = CW'(OSR/2 + 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t             st;
  logic            rx_s1, rx_s2, rx_last;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bit_i;
  logic [1:0]      smp;
  logic [SHW-1:0]  sh;
  logic [EW-1:0]   slot0, slot1;
  logic [1:0]      fcnt;

  logic vote, decide, done, push, pop, ovr_set;
  logic [BW-1:0] last_bit;
  logic [EW-1:0] new_ent;

  assign vote     = (smp[0] & smp[1]) | (smp[0] & rx_s2) | (smp[1] & rx_s2);
  assign decide   = rx_en && tick16 && st != IDLE && cnt == S_C;
  assign done     = decide && st == STOP;
  assign push     = done && !overrun && fcnt != 2'd2;
  assign ovr_set  = done && !overrun && fcnt == 2'd2;
  assign pop      = rd_pop && fcnt != 2'd0;
  assign last_bit = nine_bit ? BW'(DATA_W) : BW'(DATA_W - 1);
  assign new_ent  = {nine_bit & sh[DATA_W], ~vote, sh[DATA_W-1:0]};

  assign head_data  = slot0[DATA_W-1:0];
  assign head_ferr  = slot0[DATA_W];
  assign head_bit9  = slot0[DATA_W+1];
  assign data_avail = fcnt != 2'd0;
  assign irq        = data_avail & int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_last <= 1'b1;
      st      <= IDLE;
      cnt     <= '0;
      bit_i   <= '0;
      smp     <= '0;
      sh      <= '0;
      overrun <= 1'b0;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
      if (!rx_en) begin
        st      <= IDLE;
        overrun <= 1'b0;
      end else begin
        if (ovr_set) overrun <= 1'b1;
        if (tick16) begin
          rx_last <= rx_s2;
          if (st == IDLE) begin
            if (rx_last && !rx_s2) begin
              st  <= START;
              cnt <= CW'(1);
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == S_A) smp[0] <= rx_s2;
            if (cnt == S_B) smp[1] <= rx_s2;
            if (cnt == S_C) begin
              case (st)
                START: begin
                  st    <= vote ? IDLE : DATA;
                  bit_i <= '0;
                  sh    <= '0;
                end
                DATA: begin
                  sh[bit_i] <= vote;
                  if (bit_i == last_bit) st <= STOP;
                  else bit_i <= bit_i + 1'b1;
                end
                default: st <= IDLE;
              endcase
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      fcnt  <= '0;
    end else if (push && pop) begin
      slot0 <= new_ent;
    end else if (push) begin
      if (fcnt == 2'd0) slot0 <= new_ent;
      else slot1 <= new_ent;
      fcnt <= fcnt + 1'b1;
    end else if (pop) begin
      slot0 <= slot1;
      fcnt  <= fcnt - 1'b1;
    end
  end

  // R5
  fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= 2'd2);

  // R6
  empty_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && fcnt == 2'd1 && !done |=> !data_avail);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && rx_en |=> overrun);

  // R8
  no_store_in_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && rx_en |=> fcnt <= $past(fcnt));

  // R9
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun && st == IDLE);

  // R7
  full_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fcnt == 2'd2 && !rd_pop |=> fcnt == 2'd2);

endmodule

// File: tb/sim_uart_rx_fifo2.sv
module sim_uart_rx_fifo2;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic rx_en = 1'b0, nine_bit = 1'b0, rx_in = 1'b1, rd_pop = 1'b0, int_en = 1'b0;
  logic [7:0] head_data;
  logic head_ferr, head_bit9, overrun, data_avail, irq;
  int checks = 0, fails = 0;
  bit finished = 0;
  localparam int BITCLK = 32;

  uart_rx_fifo2 u0 (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
    .nine_bit(nine_bit), .rx_in(rx_in), .rd_pop(rd_pop), .int_en(int_en),
    .head_data(head_data), .head_ferr(head_ferr), .head_bit9(head_bit9),
    .overrun(overrun), .data_avail(data_avail), .irq(irq));

  always #2 clk = ~clk;
  initial forever begin @(negedge clk); tick16 = ~tick16; end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic line(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic nine, input logic stopv);
    nine_bit = nine;
    line(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) line(d[i], BITCLK);
    if (nine) line(b9, BITCLK);
    line(stopv, BITCLK);
    line(1'b1, 2 * BITCLK);
  endtask

  task automatic pop1();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset avail", data_avail, 0);
    chk("R8 reset overrun", overrun, 0);
    chk("R10 reset irq", irq, 0);
    rx_en = 1'b1;
    line(1'b1, 2 * BITCLK);

    // R2 R4 R6: sweep of all byte values, 8-bit mode
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b0, 1'b0, 1'b1);
      chk("R2 data", head_data, v);
      chk("R6 avail", data_avail, 1);
      if (v % 32 == 0) begin
        chk("R4 ferr clear", head_ferr, 0);
        chk("R3 bit9 zero", head_bit9, 0);
      end
      pop1();
      chk("R6 empty", data_avail, 0);
    end

    // R3: nine-bit frames
    for (int k = 0; k < 4; k++) begin
      send(8'(8'h3C ^ (k * 8'h55)), 1'(k), 1'b1, 1'b1);
      chk("R3 data", head_data, 8'h3C ^ (k * 8'h55));
      chk("R3 bit9", head_bit9, k & 1);
      pop1();
    end

    // R4 R5: framing error and per-entry status
    send(8'hA5, 1'b0, 1'b0, 1'b0);
    send(8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R4 ferr set", head_ferr, 1);
    chk("R5 head data", head_data, 8'hA5);
    chk("R5 head bit9", head_bit9, 0);
    pop1();
    chk("R5 next data", head_data, 8'h5A);
    chk("R5 next ferr", head_ferr, 0);
    chk("R5 next bit9", head_bit9, 1);
    chk("R6 still avail", data_avail, 1);
    pop1();
    chk("R6 empty", data_avail, 0);
    pop1();
    chk("R5 pop on empty", data_avail, 0);

    // R10
    send(8'h77, 1'b0, 1'b0, 1'b1);
    chk("R10 irq gated", irq, 0);
    int_en = 1'b1;
    @(negedge clk);
    chk("R10 irq on", irq, 1);
    pop1();
    chk("R10 irq off", irq, 0);

    // R7 R8: overrun
    send(8'h11, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    chk("R7 no overrun yet", overrun, 0);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    chk("R7 overrun", overrun, 1);
    chk("R7 head kept", head_data, 8'h11);
    pop1();
    chk("R7 second kept", head_data, 8'h22);
    pop1();
    chk("R7 third dropped", data_avail, 0);
    send(8'h44, 1'b0, 1'b0, 1'b1);
    chk("R8 blocked", data_avail, 0);
    chk("R8 sticky", overrun, 1);

    // R9
    rx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 overrun cleared", overrun, 0);
    send(8'h66, 1'b0, 1'b0, 1'b1);
    chk("R9 no receive", data_avail, 0);
    rx_en = 1'b1;
    line(1'b1, BITCLK);
    send(8'h55, 1'b0, 1'b0, 1'b1);
    chk("R9 receive again", head_data, 8'h55);
    chk("R9 avail", data_avail, 1);
    pop1();

    // R1: false start glitch
    line(1'b0, 6);
    line(1'b1, 4 * BITCLK);
    chk("R1 glitch ignored", data_avail, 0);
    send(8'hC3, 1'b0, 1'b0, 1'b1);
    chk("R1 after glitch", head_data, 8'hC3);
    pop1();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule